// File: doc/BRIEF.md
# Indexed Block-Transfer Configuration Target for a Two-Wire Management Bus

This block is a target on a two-wire SMBus-style management bus. It gives a host access to a small bank of 8-bit configuration bytes. Every transfer names a starting index. A write then carries a byte count followed by that many data bytes, which land in consecutive registers. A read uses a repeated START and then returns a count byte, taken from a dedicated writable register, followed by register contents in ascending order. The host ends a read with a NACK.

The two bus lines enter through a synchroniser and a short glitch filter. All bus events (START, STOP, SCL edges) are decoded from the filtered lines, and the block drives SDA only through an open-drain enable. A strap input, captured once after reset, selects one of two target addresses. The register bank appears as a flat parallel output. The clock-control fields (a 3-bit frequency select, a spread enable and a 4-bit spread amount) are also brought out separately for downstream clock logic.

Top module: `smb_cfg_target`

## Requirements
- R1: The strap is captured on the first clock after reset is released. Strap low selects 8-bit write/read addresses 0xD0/0xD1. Strap high selects 0xC0/0xC1.
- R2: The block acknowledges each byte it accepts by holding SDA low from the SCL falling edge after bit 8 until the SCL falling edge after bit 9. This covers the whole ninth SCL high period.
- R3: A write transfer is START, address with R/W=0, index N, count X, then data bytes. Data byte k (k from 0 to X-1) is stored in register N+k.
- R4: In a write, data bytes sent after the count is exhausted are NACKed and not stored.
- R5: Data bytes addressed to an index of 16 or above are ACKed and discarded. The 16 registers are left unchanged.
- R6: A read transfer is START, address with R/W=0, index N, repeated START, address with R/W=1. The first byte returned is register 8. It is followed by registers N, N+1, and so on. Any index of 16 or above reads 0x00.
- R7: When the host NACKs a read byte, the block releases SDA and sends nothing more until the next START.
- R8: When the address does not match, the block gives no ACK. It ignores every following byte until a START or STOP.
- R9: A START or STOP that arrives partway through a byte aborts the transfer. Bytes already completed stay written, and the partial byte is dropped.
- R10: A pulse of 2 clock cycles or less on SDA is ignored and does not create a START or STOP.
- R11: `cpu_fsel_o` is register 0 bits 2:0. `ssc_en_o` is register 0 bit 4. `ssc_amt_o` is register 3 bits 3:0.
- R12: After reset, all registers are 0x00 except register 8, which is 0x10. SDA is released.
- R13: The block changes its SDA drive only while filtered SCL is low. The one exception is release on START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Address strap, captured after reset |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| cpu_fsel_o | output | 3 | Frequency select field |
| ssc_en_o | output | 1 | Spread enable |
| ssc_amt_o | output | 4 | Spread amount code |
| regs_o | output | 128 | Register bank, register i at bits 8i+7:8i |

## Verification
The hardest case to reach is a pulse on SDA while SCL is high that is too short to pass the filter. Without the filter, such a pulse would read as a START and abort a write. The bench gets there by lowering SDA for exactly two clocks in the middle of a data bit's high phase, with inputs driven on the falling clock edge. It then checks that the write completes. Mid-byte aborts and overrun past both the count and the bank are reached by sending deliberately short or long bursts, and the results are read back as register contents.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } smb_state_e;

  typedef enum logic [1:0] {
    STG_ADDR,
    STG_IDX,
    STG_CNT,
    STG_DATA
  } smb_stage_e;
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      hist_q <= '1;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist_q)       out_q <= 1'b1;
      else if (~|hist_q) out_q <= 1'b0;
    end
  end

  assign line_o = out_q;

  AST_FILT_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_q != $past(out_q)) |-> ($past(hist_q) == {FILT_LEN{out_q}})); // R10
endmodule

// File: rtl/smb_bus_cond.sv
module smb_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

  AST_COND_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({scl_rise_o, scl_fall_o, start_o, stop_o})); // R13
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter int         NUM_REGS = 16,
  parameter int         CNT_IDX  = 8,
  parameter logic [7:0] CNT_RST  = 8'h10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [7:0]            widx_i,
  input  logic [7:0]            wdata_i,
  input  logic [7:0]            ridx_i,
  output logic [7:0]            rdata_o,
  output logic [7:0]            cnt_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int         IDX_W = $clog2(NUM_REGS);
  localparam logic [8:0] NREG9 = 9'(NUM_REGS);

  logic [7:0] mem_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] RST_V = (i == CNT_IDX) ? CNT_RST : 8'h00;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     mem_q[i] <= RST_V;
      else if (we_i && widx_i[IDX_W-1:0] == IDX_W'(i)) mem_q[i] <= wdata_i;
    end
    assign regs_o[i*8 +: 8] = mem_q[i];
  end

  assign rdata_o = ({1'b0, ridx_i} < NREG9) ? mem_q[ridx_i[IDX_W-1:0]] : 8'h00;
  assign cnt_o   = mem_q[CNT_IDX];

  AST_WR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> ({1'b0, widx_i} < NREG9)); // R5
endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target #(
  parameter int         NUM_REGS    = 16,
  parameter int         CNT_IDX     = 8,
  parameter logic [7:0] CNT_RST     = 8'h10,
  parameter logic [6:0] ADDR_LO     = 7'h68,
  parameter logic [6:0] ADDR_HI     = 7'h60,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  addr_sel_i,
  output logic                  sda_oe_o,
  output logic [2:0]            cpu_fsel_o,
  output logic                  ssc_en_o,
  output logic [3:0]            ssc_amt_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  import smb_cfg_pkg::*;

  localparam logic [8:0] NREG9   = 9'(NUM_REGS);
  localparam int         FSEL_RG = 0;
  localparam int         SSC_RG  = 3;

  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_w, stop_w;

  smb_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(scl_i), .line_o(scl_f));
  smb_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(sda_i), .line_o(sda_f));

  smb_bus_cond u_cond (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_f), .sda_i(sda_f),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_w), .stop_o(stop_w));

  smb_state_e state_q;
  smb_stage_e stage_q;
  logic [3:0] bit_cnt_q;
  logic [7:0] rx_sh_q, tx_sh_q, ptr_q, left_q;
  logic       ack_q, rd_pend_q, host_ack_q;
  logic       strap_q, strap_done_q;
  logic [6:0] own_addr;
  logic       we;
  logic [7:0] rdata, cnt_w;

  // strap capture, once after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q      <= 1'b0;
      strap_done_q <= 1'b0;
    end else if (!strap_done_q) begin
      strap_q      <= addr_sel_i;
      strap_done_q <= 1'b1;
    end
  end

  assign own_addr = strap_q ? ADDR_HI : ADDR_LO;

  assign we = (state_q == ST_RX) && (stage_q == STG_DATA) && scl_fall &&
              (bit_cnt_q == 4'd8) && (left_q != 8'h00) && ({1'b0, ptr_q} < NREG9);

  smb_regbank #(.NUM_REGS(NUM_REGS), .CNT_IDX(CNT_IDX), .CNT_RST(CNT_RST)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(we), .widx_i(ptr_q), .wdata_i(rx_sh_q),
    .ridx_i(ptr_q), .rdata_o(rdata), .cnt_o(cnt_w), .regs_o(regs_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      stage_q    <= STG_ADDR;
      bit_cnt_q  <= '0;
      rx_sh_q    <= '0;
      tx_sh_q    <= '1;
      ptr_q      <= '0;
      left_q     <= '0;
      ack_q      <= 1'b0;
      rd_pend_q  <= 1'b0;
      host_ack_q <= 1'b0;
    end else if (start_w) begin
      state_q   <= ST_RX;
      stage_q   <= STG_ADDR;
      bit_cnt_q <= '0;
      ack_q     <= 1'b0;
      rd_pend_q <= 1'b0;
    end else if (stop_w) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      ack_q     <= 1'b0;
      rd_pend_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise && bit_cnt_q < 4'd8) begin
            rx_sh_q   <= {rx_sh_q[6:0], sda_f};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_fall && bit_cnt_q == 4'd8) begin
            bit_cnt_q <= '0;
            state_q   <= ST_RX_ACK;
            ack_q     <= 1'b1;
            unique case (stage_q)
              STG_ADDR: begin
                if (rx_sh_q[7:1] != own_addr) begin
                  state_q <= ST_IDLE;
                  ack_q   <= 1'b0;
                end else if (rx_sh_q[0]) begin
                  rd_pend_q <= 1'b1;
                end else begin
                  stage_q <= STG_IDX;
                end
              end
              STG_IDX: begin
                ptr_q   <= rx_sh_q;
                stage_q <= STG_CNT;
              end
              STG_CNT: begin
                left_q  <= rx_sh_q;
                stage_q <= STG_DATA;
              end
              STG_DATA: begin
                if (left_q != 8'h00) begin
                  left_q <= left_q - 8'd1;
                  ptr_q  <= ptr_q + 8'd1;
                end else begin
                  ack_q <= 1'b0;
                end
              end
              default: ;
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            ack_q <= 1'b0;
            if (rd_pend_q) begin
              state_q   <= ST_TX;
              tx_sh_q   <= cnt_w;
              rd_pend_q <= 1'b0;
            end else begin
              state_q <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt_q == 4'd7) begin
              state_q   <= ST_TX_ACK;
              bit_cnt_q <= '0;
            end else begin
              tx_sh_q   <= {tx_sh_q[6:0], 1'b1};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) host_ack_q <= ~sda_f;
          if (scl_fall) begin
            if (host_ack_q) begin
              state_q <= ST_TX;
              tx_sh_q <= rdata;
              ptr_q   <= ptr_q + 8'd1;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o   = ((state_q == ST_RX_ACK) && ack_q) ||
                      ((state_q == ST_TX) && !tx_sh_q[7]);
  assign cpu_fsel_o = regs_o[FSEL_RG*8 +: 3];
  assign ssc_en_o   = regs_o[FSEL_RG*8 + 4];
  assign ssc_amt_o  = regs_o[SSC_RG*8 +: 4];

  AST_SDA_LOW_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_f && $past(scl_f) && !$past(start_w) && !$past(stop_w)) |-> $stable(sda_oe_o)); // R13
  AST_ACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_RX_ACK && state_q == ST_RX_ACK) |-> $stable(sda_oe_o)); // R2
  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_w) |-> !sda_oe_o); // R9
  AST_BIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= 4'd8); // R3
  AST_NACK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_TX_ACK && state_q == ST_IDLE) |-> !sda_oe_o); // R7
endmodule

// File: tb/smb_cfg_target_tb.sv
module smb_cfg_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_host = 1'b1, sda_host = 1'b1, addr_sel = 1'b0;
  logic sda_oe;
  logic [2:0] cpu_fsel;
  logic ssc_en;
  logic [3:0] ssc_amt;
  logic [127:0] regs;
  wire sda_line = sda_host & ~sda_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_cfg_target u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_host), .sda_i(sda_line),
    .addr_sel_i(addr_sel), .sda_oe_o(sda_oe), .cpu_fsel_o(cpu_fsel),
    .ssc_en_o(ssc_en), .ssc_amt_o(ssc_amt), .regs_o(regs));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_host = 1; wq(); scl_host = 1; wq(); sda_host = 0; wq(); scl_host = 0; wq();
  endtask

  task automatic bus_stop();
    sda_host = 0; wq(); scl_host = 1; wq(); sda_host = 1; wq();
  endtask

  task automatic put_bit(input logic b, input bit glitch);
    sda_host = b; wq(); scl_host = 1; wq();
    if (glitch) begin
      sda_host = 0; repeat (2) @(negedge clk); sda_host = b;
    end
    wq(); scl_host = 0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked, input int glitch_bit = -1);
    for (int i = 7; i >= 0; i--) put_bit(b[i], (i == glitch_bit));
    sda_host = 1; wq(); scl_host = 1; wq();
    acked = ~sda_line; wq();
    if (sda_line !== ~acked) acked = 1'bx; // ack must hold through high phase
    scl_host = 0; wq();
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_host = 1; wq(); scl_host = 1; wq(); b[i] = sda_line; wq(); scl_host = 0; wq();
    end
    sda_host = ~ack; wq(); scl_host = 1; wq(); wq(); scl_host = 0; wq();
    sda_host = 1;
  endtask

  task automatic do_reset(input logic strap);
    addr_sel = strap; rst_ni = 0; scl_host = 1; sda_host = 1;
    repeat (4) @(negedge clk); rst_ni = 1; repeat (4) @(negedge clk);
    for (int i = 0; i < 16; i++) model[i] = (i == 8) ? 8'h10 : 8'h00;
  endtask

  task automatic chk_regs(input string req);
    for (int i = 0; i < 16; i++) chk(req, regs[i*8 +: 8], model[i]);
  endtask

  task automatic t_reset();
    chk("R12 sda released", sda_oe, 0);
    chk_regs("R12 reset values");
  endtask

  task automatic t_write_basic();
    logic a;
    bus_start();
    send_byte(8'hD0, a); chk("R1 addr ack", a, 1);
    send_byte(8'h00, a); chk("R2 index ack", a, 1);
    send_byte(8'h04, a); chk("R2 count ack", a, 1);
    send_byte(8'h15, a); chk("R3 data0 ack", a, 1);
    send_byte(8'hA2, a); chk("R3 data1 ack", a, 1);
    send_byte(8'h33, a); chk("R3 data2 ack", a, 1);
    send_byte(8'h0B, a); chk("R3 data3 ack", a, 1);
    bus_stop();
    model[0] = 8'h15; model[1] = 8'hA2; model[2] = 8'h33; model[3] = 8'h0B;
    chk_regs("R3 block write");
    chk("R11 fsel", cpu_fsel, 3'd5);
    chk("R11 ssc_en", ssc_en, 1);
    chk("R11 ssc_amt", ssc_amt, 4'hB);
  endtask

  task automatic t_read_basic();
    logic a; logic [7:0] b;
    bus_start();
    send_byte(8'hD0, a); send_byte(8'h08, a); send_byte(8'h01, a); send_byte(8'h03, a);
    bus_stop();
    model[8] = 8'h03;
    chk("R3 count reg write", regs[64 +: 8], 8'h03);
    bus_start();
    send_byte(8'hD0, a); send_byte(8'h01, a);
    bus_start();
    send_byte(8'hD1, a); chk("R6 read addr ack", a, 1);
    recv_byte(1, b); chk("R6 count byte", b, 8'h03);
    recv_byte(1, b); chk("R6 byte N", b, 8'hA2);
    recv_byte(1, b); chk("R6 byte N+1", b, 8'h33);
    recv_byte(0, b); chk("R6 byte N+2", b, 8'h0B);
    chk("R7 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_mismatch();
    logic a;
    bus_start();
    send_byte(8'hC0, a); chk("R8 wrong addr nack", a, 0);
    send_byte(8'h00, a); chk("R8 ignored idx", a, 0);
    send_byte(8'h01, a); chk("R8 ignored cnt", a, 0);
    send_byte(8'h77, a); chk("R8 ignored data", a, 0);
    bus_stop();
    chk_regs("R8 regs untouched");
  endtask

  task automatic t_out_of_range();
    logic a; logic [7:0] b;
    bus_start();
    send_byte(8'hD0, a); send_byte(8'h0F, a); send_byte(8'h03, a);
    send_byte(8'hE1, a); chk("R5 last reg ack", a, 1);
    send_byte(8'hE2, a); chk("R5 beyond ack", a, 1);
    send_byte(8'hE3, a); chk("R5 beyond ack 2", a, 1);
    bus_stop();
    model[15] = 8'hE1;
    chk_regs("R5 discarded");
    bus_start();
    send_byte(8'hD0, a); send_byte(8'h0F, a);
    bus_start();
    send_byte(8'hD1, a);
    recv_byte(1, b); chk("R6 count", b, 8'h03);
    recv_byte(1, b); chk("R6 reg15", b, 8'hE1);
    recv_byte(1, b); chk("R6 beyond zero", b, 8'h00);
    recv_byte(0, b); chk("R6 beyond zero 2", b, 8'h00);
    bus_stop();
  endtask

  task automatic t_over_count();
    logic a;
    bus_start();
    send_byte(8'hD0, a); send_byte(8'h04, a); send_byte(8'h01, a);
    send_byte(8'h44, a); chk("R3 counted byte ack", a, 1);
    send_byte(8'h55, a); chk("R4 extra nack", a, 0);
    bus_stop();
    model[4] = 8'h44;
    chk_regs("R4 extra not stored");
  endtask

  task automatic t_abort();
    logic a;
    bus_start();
    send_byte(8'hD0, a); send_byte(8'h06, a); send_byte(8'h03, a);
    send_byte(8'h66, a);
    for (int i = 0; i < 4; i++) put_bit(1'b1, 0);
    bus_stop();
    model[6] = 8'h66;
    chk_regs("R9 abort keeps prior");
    chk("R9 released", sda_oe, 0);
  endtask

  task automatic t_glitch();
    logic a;
    bus_start();
    send_byte(8'hD0, a); send_byte(8'h09, a); send_byte(8'h01, a);
    send_byte(8'hF7, a, 4); chk("R10 glitched byte ack", a, 1);
    bus_stop();
    model[9] = 8'hF7;
    chk("R10 glitch ignored", regs[72 +: 8], 8'hF7);
  endtask

  task automatic t_strap_high();
    logic a;
    do_reset(1'b1);
    bus_start();
    send_byte(8'hD0, a); chk("R1 low addr rejected", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'hC0, a); chk("R1 high addr ack", a, 1);
    send_byte(8'h02, a); send_byte(8'h01, a); send_byte(8'h5A, a);
    bus_stop();
    model[2] = 8'h5A;
    chk_regs("R1 write via alt addr");
  endtask

  initial begin
    do_reset(1'b0);
    t_reset();
    t_write_basic();
    t_read_basic();
    t_mismatch();
    t_out_of_range();
    t_over_count();
    t_abort();
    t_glitch();
    t_strap_high();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule